// File: doc/BRIEF.md
# Linked-List Transmit DMA Engine

This block moves outgoing frames from system memory to a byte-wide transmit stream. Software builds a ring of descriptors in memory. Each descriptor is four 32-bit words: a status word, a control word holding the byte count and segment flags, the byte address of the frame buffer, and the byte address of the next descriptor. Software points the engine at the first descriptor, sets the DMA enable and writes a start bit. From then on the engine fetches each descriptor and checks that it owns it. It reads the buffer through a word-addressed memory port, unpacks the bytes and queues them in an internal byte FIFO, and they leave on a valid/ready stream. When a frame has fully left the block, the engine clears the ownership bit in memory and follows the next pointer.

If the engine meets a descriptor it does not own, it parks in a suspended state and keeps its position in the ring. The next start write resumes from that same descriptor. The stream runs in one of two modes. In cut-through mode bytes go out as soon as they are queued. In store-and-forward mode a frame is held back until all of its bytes sit in the FIFO. A separate transmitter enable gates the stream output without stopping the fetch side.

Top module: `tx_chain_dma`

## Requirements
- R1: After synchronous reset, every register reads 0, the engine is neither busy nor suspended, `tx_valid` is 0 and no memory request is made.
- R2: A write to offset 0x14 with bit 31 set starts the engine only when bit 30 (DMA enable) of that register is also set after the write. The engine then reads the four descriptor words at the word address of the current pointer, in order. A start with DMA enable clear causes no memory access.
- R3: For an owned descriptor (status bit 31 = 1), the engine streams the bytes of its buffer in ascending address order. The byte count is taken from control bits [10:0], the buffer may start at any byte offset, and memory words are little-endian (byte 0 in bits [7:0]).
- R4: `tx_last` is 1 on the final byte of a descriptor when control bit 30 is set. It is 0 on every byte of a descriptor whose bit 30 is clear.
- R5: Once the last byte of a frame has been accepted, the engine writes the status word back with bit 31 cleared and all other bits unchanged. This is the only memory write per descriptor.
- R6: After the write-back, the current pointer (readable at 0xB4) takes the descriptor's next pointer. A next pointer that leads back to the first descriptor makes the engine wrap around the ring.
- R7: A fetched descriptor with status bit 31 = 0 is not transmitted or written. The engine stops with status bit 0 (suspended) = 1, bit 1 (busy) = 0, and the pointer still on that descriptor. Memory changes alone do not restart it, and the next start resumes at that descriptor.
- R8: With bit 1 of 0x14 (store-and-forward) set, no byte of a frame that fits in the FIFO is presented until its last buffer word has been read. The whole frame then goes out in consecutive cycles while `tx_ready` is 1.
- R9: With store-and-forward clear, bytes are presented while the buffer is still being read.
- R10: While bit 31 of offset 0x10 (transmitter enable) is 0, `tx_valid` stays 0 and queued bytes are kept. Setting the bit releases them unchanged.
- R11: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold their values in the next cycle, provided the transmitter enable stays set.
- R12: Clearing DMA enable while a descriptor is in flight lets that descriptor finish and be written back. The engine then halts with busy = 0 and suspended = 0, and leaves the next descriptor untouched.
- R13: A descriptor with a byte count of 0 produces no stream bytes, yet it is still written back and followed.
- R14: Offset 0x14 bit 31 always reads 0. A write to the base register at 0x20 loads the current pointer at 0xB4 when the engine is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Stream sink ready |

## Verification
Most internal state in this block becomes visible at the ports within a few dozen cycles. Suppose the byte unpacker uses the wrong lane or the wrong length. The first mismatched byte then differs from the reference queue on the very handshake where it appears. Suppose the pointer, ownership or write-back logic is wrong. Then the next descriptor fetch or the status word in memory is wrong as soon as the frame drains, and the bench checks both against the ring it built. A faulty release gate changes the cycle of the first valid byte relative to the last buffer read, and a faulty stall path changes the data during the first stalled cycle.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    // descriptor word fields
    localparam int OWN_BIT  = 31;
    localparam int LAST_BIT = 30;

    // register offsets
    localparam int          REG_AW     = 8;
    localparam logic [7:0]  OFS_TXEN   = 8'h10;
    localparam logic [7:0]  OFS_DMACTL = 8'h14;
    localparam logic [7:0]  OFS_BASE   = 8'h20;
    localparam logic [7:0]  OFS_STAT   = 8'hB0;
    localparam logic [7:0]  OFS_CURR   = 8'hB4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC,
        ST_DCHK,
        ST_BREQ,
        ST_BWAIT,
        ST_PUSH,
        ST_DRAIN,
        ST_WBACK
    } eng_state_t;

    typedef struct packed {
        logic       last;
        logic [7:0] data;
    } tx_byte_t;

    function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] lane);
        return w[{lane, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
    import txdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              suspended,
    input  logic [31:0]       cur_desc,
    output logic              tx_en,
    output logic              dma_en,
    output logic              sf_mode,
    output logic [31:0]       base_addr,
    output logic              kick,
    output logic              base_wr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en     <= 1'b0;
            dma_en    <= 1'b0;
            sf_mode   <= 1'b0;
            base_addr <= '0;
            kick      <= 1'b0;
            base_wr   <= 1'b0;
        end else begin
            kick    <= 1'b0;
            base_wr <= 1'b0;
            if (reg_wr) begin
                case (reg_addr)
                    OFS_TXEN: tx_en <= reg_wdata[31];
                    OFS_DMACTL: begin
                        dma_en  <= reg_wdata[30];
                        sf_mode <= reg_wdata[1];
                        kick    <= reg_wdata[31];
                    end
                    OFS_BASE: begin
                        base_addr <= reg_wdata;
                        base_wr   <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_TXEN:   reg_rdata = {tx_en, 31'b0};
            OFS_DMACTL: reg_rdata = {1'b0, dma_en, 28'b0, sf_mode, 1'b0};
            OFS_BASE:   reg_rdata = base_addr;
            OFS_STAT:   reg_rdata = {30'b0, busy, suspended};
            OFS_CURR:   reg_rdata = cur_desc;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/txdma_fifo.sv
module txdma_fifo
    import txdma_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  tx_byte_t push_byte,
    input  logic     pop,
    output tx_byte_t head,
    output logic     empty,
    output logic     full
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] CNT_FULL = (PW+1)'(DEPTH);

    tx_byte_t        store [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [PW:0]     cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= push_byte;
                wr_ptr        <= wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    assign head  = store[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_FULL);

    // R3: the engine never pushes into a full queue
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> cnt < CNT_FULL);
    // R3: the stream never takes a byte from an empty queue
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt != '0);

endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
    import txdma_pkg::*;
#(
    parameter int AW    = 12,
    parameter int LEN_W = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kick,
    input  logic          dma_en,
    input  logic          base_wr,
    input  logic [31:0]   base_addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          push,
    output tx_byte_t      push_byte,
    input  logic          fifo_full,
    input  logic          fifo_empty,
    output logic          fetch_done,
    output logic          busy,
    output logic          suspended,
    output logic [31:0]   cur_desc
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    eng_state_t        state;
    logic [1:0]        cnt;
    logic              cap_vld;
    logic [1:0]        cap_idx;
    logic [31:0]       stat_w, bufp, next_p, cur_p, word_buf;
    logic [LEN_W-1:0]  len_w, rem;
    logic              last_flag, fdone, susp;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        push      = 1'b0;
        push_byte = '0;
        case (state)
            ST_DESC: begin
                mem_req  = 1'b1;
                mem_addr = cur_p[AW+1:2] + AW'(cnt);
            end
            ST_BREQ: begin
                if (rem != '0) begin
                    mem_req  = 1'b1;
                    mem_addr = bufp[AW+1:2];
                end
            end
            ST_PUSH: begin
                if (!fifo_full) begin
                    push           = 1'b1;
                    push_byte.data = pick_byte(word_buf, bufp[1:0]);
                    push_byte.last = (rem == ONE) && last_flag;
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_p[AW+1:2];
                mem_wdata = stat_w & ~(32'h1 << OWN_BIT);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            cap_vld   <= 1'b0;
            cap_idx   <= '0;
            stat_w    <= '0;
            len_w     <= '0;
            last_flag <= 1'b0;
            bufp      <= '0;
            next_p    <= '0;
            cur_p     <= '0;
            word_buf  <= '0;
            rem       <= '0;
            fdone     <= 1'b0;
            susp      <= 1'b0;
        end else begin
            cap_vld <= (state == ST_DESC);
            cap_idx <= cnt;
            if (cap_vld) begin
                case (cap_idx)
                    2'd0: stat_w <= mem_rdata;
                    2'd1: begin
                        len_w     <= mem_rdata[LEN_W-1:0];
                        last_flag <= mem_rdata[LAST_BIT];
                    end
                    2'd2: bufp   <= mem_rdata;
                    default: next_p <= mem_rdata;
                endcase
            end
            if (base_wr && state == ST_IDLE) cur_p <= base_addr;

            case (state)
                ST_IDLE: begin
                    if (kick && dma_en) begin
                        state <= ST_DESC;
                        cnt   <= '0;
                        susp  <= 1'b0;
                    end
                end
                ST_DESC: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == 2'd3) state <= ST_DCHK;
                end
                ST_DCHK: begin
                    if (!stat_w[OWN_BIT]) begin
                        susp  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        rem   <= len_w;
                        fdone <= 1'b0;
                        state <= ST_BREQ;
                    end
                end
                ST_BREQ: begin
                    if (rem == '0) begin
                        fdone <= 1'b1;
                        state <= ST_DRAIN;
                    end else begin
                        state <= ST_BWAIT;
                    end
                end
                ST_BWAIT: begin
                    word_buf <= mem_rdata;
                    state    <= ST_PUSH;
                end
                ST_PUSH: begin
                    if (!fifo_full) begin
                        bufp <= bufp + 32'd1;
                        rem  <= rem - ONE;
                        if (rem == ONE) begin
                            fdone <= 1'b1;
                            state <= ST_DRAIN;
                        end else if (bufp[1:0] == 2'b11) begin
                            state <= ST_BREQ;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (fifo_empty) state <= ST_WBACK;
                end
                ST_WBACK: begin
                    cur_p <= next_p;
                    cnt   <= '0;
                    state <= dma_en ? ST_DESC : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign fetch_done = fdone;
    assign busy       = (state != ST_IDLE);
    assign suspended  = susp;
    assign cur_desc   = cur_p;

    // R7: a suspended engine is parked
    a_r7_susp_parked: assert property (@(posedge clk) disable iff (rst)
        susp |-> state == ST_IDLE);
    // R5: one status write per descriptor, never back to back
    a_r5_single_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);
    // R5: the write-back happens only after the queue has drained
    a_r5_after_drain: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> fifo_empty);
    // R3: bytes are only pushed while the frame still has bytes left
    a_r3_push_in_frame: assert property (@(posedge clk) disable iff (rst)
        push |-> rem != '0);

endmodule

// File: rtl/tx_chain_dma.sv
module tx_chain_dma
    import txdma_pkg::*;
#(
    parameter int AW         = 12,
    parameter int FIFO_DEPTH = 32,
    parameter int LEN_W      = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [7:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready
);

    logic        tx_en, dma_en, sf_mode, kick, base_wr;
    logic [31:0] base_addr, cur_desc;
    logic        busy, suspended, fetch_done;
    logic        push, pop, fifo_empty, fifo_full, release_ok;
    tx_byte_t    push_byte, head;

    txdma_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .suspended (suspended),
        .cur_desc  (cur_desc),
        .tx_en     (tx_en),
        .dma_en    (dma_en),
        .sf_mode   (sf_mode),
        .base_addr (base_addr),
        .kick      (kick),
        .base_wr   (base_wr)
    );

    txdma_engine #(.AW(AW), .LEN_W(LEN_W)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .kick       (kick),
        .dma_en     (dma_en),
        .base_wr    (base_wr),
        .base_addr  (base_addr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .push       (push),
        .push_byte  (push_byte),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .fetch_done (fetch_done),
        .busy       (busy),
        .suspended  (suspended),
        .cur_desc   (cur_desc)
    );

    txdma_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_byte (push_byte),
        .pop       (pop),
        .head      (head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    // store-and-forward holds the frame until fully fetched (or queue full)
    assign release_ok = !sf_mode || fetch_done || fifo_full;
    assign tx_valid   = !fifo_empty && tx_en && release_ok;
    assign tx_data    = head.data;
    assign tx_last    = head.last;
    assign pop        = tx_valid && tx_ready;

    // R11: a stalled byte is held while the transmitter stays enabled
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (!tx_en || (tx_valid && $stable(tx_data) && $stable(tx_last))));
    // R10: nothing leaves while the transmitter is off
    a_r10_gate: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !tx_valid);
    // R8: in store-and-forward mode no byte goes out mid-fetch of a short frame
    a_r8_hold_back: assert property (@(posedge clk) disable iff (rst)
        (sf_mode && !fifo_full && !fetch_done) |-> !tx_valid);

endmodule

// File: tb/tx_chain_dma_test.sv
module tx_chain_dma_test;
    localparam int AW = 10;
    localparam logic [7:0] A_TXEN = 8'h10, A_CTL = 8'h14, A_BASE = 8'h20,
                            A_STAT = 8'hB0, A_CURR = 8'hB4;
    localparam logic [31:0] OWN = 32'h8000_0000, LST = 32'h4000_0000,
                            FST = 32'h2000_0000, CHN = 32'h0100_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = 8'h0;
    logic [31:0]   reg_wdata = 32'h0;
    logic [31:0]   reg_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = 32'h0;
    logic          tx_valid, tx_last;
    logic [7:0]    tx_data;
    logic          tx_ready = 1'b1;

    always #5 clk = ~clk;

    tx_chain_dma #(.AW(AW), .FIFO_DEPTH(32), .LEN_W(11)) uut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    logic [31:0] mem [1024];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    int tests = 0, fails = 0, cyc = 0;
    logic [8:0] exp_q [$];
    int reads = 0, first_rd = -1, last_buf_rd = 0, buf_lo = 0, buf_hi = -1;
    int first_valid = 0, last_valid = 0, last_pops = 0, stall_checks = 0;
    bit txen_model = 0, bp_mode = 0, prev_stall = 0;
    logic [8:0] prev_byte = 9'h0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    // reference: stream, stall and gate checks on every clock
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (mem_req && !mem_we) begin
                reads++;
                if (first_rd < 0) first_rd = int'(mem_addr);
                if (int'(mem_addr) >= buf_lo && int'(mem_addr) <= buf_hi) last_buf_rd = cyc;
            end
            if (prev_stall) begin
                stall_checks++;
                chk(tx_valid && {tx_last, tx_data} == prev_byte, "R11 hold", {tx_valid, tx_last, tx_data}, {1'b1, prev_byte});
            end
            prev_stall = tx_valid && !tx_ready;
            prev_byte  = {tx_last, tx_data};
            if (tx_valid && !txen_model)
                chk(0, "R10 valid while off", 1, 0);
            if (tx_valid) begin
                if (first_valid == 0) first_valid = cyc;
                last_valid = cyc;
            end
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) chk(0, "R3 unexpected byte", {23'b0, tx_last, tx_data}, 0);
                else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk(tx_data == e[7:0], "R3 byte", tx_data, e[7:0]);
                    chk(tx_last == e[8], "R4 last flag", tx_last, e[8]);
                    if (tx_last) last_pops++;
                end
            end
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(posedge clk) begin
        #1 tx_ready <= bp_mode ? (cyc % 3 != 0) : 1'b1;
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == A_TXEN) txen_model = d[31];
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic wait_stop(input bit want_susp, input string req);
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(A_STAT, s);
            if (!s[1] && s[0] == want_susp) return;
        end
        chk(0, req, s, {30'b0, 1'b0, want_susp});
    endtask

    task automatic desc(input int a, input logic [31:0] st, input logic [31:0] ctl,
                        input logic [31:0] bp, input logic [31:0] nx);
        mem[a/4] = st; mem[a/4+1] = ctl; mem[a/4+2] = bp; mem[a/4+3] = nx;
    endtask

    task automatic fill(input int a, input int len, input int seed, input bit lastf, input bit expect_it);
        for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            v = 8'((seed + i * 7) & 255);
            mem[(a+i)/4][((a+i)%4)*8 +: 8] = v;
            if (expect_it) exp_q.push_back({lastf && (i == len-1), v});
        end
        buf_lo = a / 4; buf_hi = (a + len - 1) / 4;
    endtask

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(A_CTL, d);  chk(d == 0, "R1 ctl", d, 0);
        rd(A_BASE, d); chk(d == 0, "R1 base", d, 0);
        rd(A_STAT, d); chk(d == 0, "R1 status", d, 0);
        rd(A_CURR, d); chk(d == 0, "R1 cur", d, 0);
        chk(!tx_valid && !mem_req, "R1 outputs", {tx_valid, mem_req}, 0);

        // ring of three: 0x100 -> 0x110 -> 0x120 -> 0x100
        desc(32'h100, OWN | 32'h1234, FST | LST | 5, 32'h400, 32'h110);
        fill(32'h400, 5, 3, 1, 1);
        desc(32'h110, OWN, FST | 7, 32'h481, 32'h120);
        fill(32'h481, 7, 40, 0, 1);
        desc(32'h120, OWN | 32'h55, FST | LST | CHN, 32'h500, 32'h100);
        buf_lo = 0; buf_hi = -1;

        wr(A_TXEN, 32'h8000_0000);
        wr(A_BASE, 32'h100);
        repeat (3) @(posedge clk);
        rd(A_CURR, d); chk(d == 32'h100, "R14 base loads pointer", d, 32'h100);

        reads = 0;
        wr(A_CTL, 32'h8000_0000);
        repeat (10) @(posedge clk);
        chk(reads == 0, "R2 start without enable", reads, 0);
        rd(A_STAT, d); chk(d == 0, "R2 stays idle", d, 0);

        first_rd = -1; last_pops = 0;
        wr(A_CTL, 32'hC000_0000);
        wait_stop(1, "R7 suspend after ring");
        chk(first_rd == 32'h40, "R2 first fetch address", first_rd, 32'h40);
        chk(exp_q.size() == 0, "R3 all bytes sent", exp_q.size(), 0);
        chk(last_pops == 1, "R4 last count", last_pops, 1);
        chk(mem[32'h40] == 32'h1234, "R5 status write-back", mem[32'h40], 32'h1234);
        chk(mem[32'h44] == 32'h0, "R5 second status", mem[32'h44], 0);
        chk(mem[32'h48] == 32'h55, "R13 zero-length write-back", mem[32'h48], 32'h55);
        rd(A_CURR, d); chk(d == 32'h100, "R6 wrapped pointer", d, 32'h100);
        rd(A_STAT, d); chk(d == 32'h1, "R7 status", d, 1);
        rd(A_CTL, d);  chk(d == 32'h4000_0000, "R14 kick reads zero", d, 32'h4000_0000);

        // R7: memory change alone does not restart; R9 cut-through
        desc(32'h100, OWN, FST | LST | 20, 32'h600, 32'h110);
        fill(32'h600, 20, 9, 1, 1);
        reads = 0;
        repeat (10) @(posedge clk);
        chk(reads == 0, "R7 no self restart", reads, 0);
        first_valid = 0;
        wr(A_CTL, 32'hC000_0000);
        wait_stop(1, "R7 resume and suspend");
        chk(first_valid < last_buf_rd, "R9 early output", first_valid, last_buf_rd);
        chk(exp_q.size() == 0, "R9 frame complete", exp_q.size(), 0);
        rd(A_CURR, d); chk(d == 32'h110, "R7 parked on unowned", d, 32'h110);

        // R8 store-and-forward
        desc(32'h110, OWN, FST | LST | 20, 32'h700, 32'h120);
        fill(32'h700, 20, 77, 1, 1);
        first_valid = 0;
        wr(A_CTL, 32'hC000_0002);
        wait_stop(1, "R8 run");
        chk(first_valid > last_buf_rd, "R8 held until fetched", first_valid, last_buf_rd);
        chk(last_valid - first_valid + 1 == 20, "R8 contiguous", last_valid - first_valid + 1, 20);
        chk(exp_q.size() == 0, "R8 frame complete", exp_q.size(), 0);

        // R10 transmitter gate, R11 backpressure
        wr(A_TXEN, 32'h0);
        desc(32'h120, OWN, FST | LST | 6, 32'h800, 32'h100);
        fill(32'h800, 6, 200, 1, 1);
        wr(A_CTL, 32'hC000_0000);
        repeat (40) @(posedge clk);
        chk(exp_q.size() == 6, "R10 bytes kept", exp_q.size(), 6);
        rd(A_STAT, d); chk(d == 32'h2, "R10 busy while gated", d, 2);
        bp_mode = 1; stall_checks = 0;
        wr(A_TXEN, 32'h8000_0000);
        wait_stop(1, "R10 release");
        chk(exp_q.size() == 0, "R10 released bytes", exp_q.size(), 0);
        chk(stall_checks > 0, "R11 stalls exercised", stall_checks, 1);
        bp_mode = 0;

        // R12 disable mid-frame
        desc(32'h100, OWN | 32'h7, FST | LST | 20, 32'hA00, 32'h110);
        fill(32'hA00, 20, 11, 1, 1);
        desc(32'h110, OWN, FST | LST | 4, 32'hB00, 32'h120);
        wr(A_CTL, 32'hC000_0000);
        repeat (8) @(posedge clk);
        wr(A_CTL, 32'h0);
        wait_stop(0, "R12 halt");
        chk(mem[32'h40] == 32'h7, "R12 current finished", mem[32'h40], 32'h7);
        chk(mem[32'h44] == OWN, "R12 next untouched", mem[32'h44], OWN);
        rd(A_CURR, d); chk(d == 32'h110, "R12 pointer advanced", d, 32'h110);
        rd(A_STAT, d); chk(d == 0, "R12 status", d, 0);
        chk(exp_q.size() == 0, "R12 frame complete", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule